// File: doc/BRIEF.md
# Scan-Port Nonvolatile Programming Controller

This block is a boundary-scan test access port that also manages a small nonvolatile store. A 16-state TAP controller, advanced by TMS on rising TCK edges, steers an 8-bit instruction register and three data registers: a 1-bit bypass stage, a fixed 32-bit device identity word, and a 32-bit user signature register. The opcode held in the instruction register picks which data register sits between TDI and TDO.

Destructive and write operations are bulk erase, security lock, signature write and discharge. They run only while a sticky programming mode is armed, and that mode is armed and disarmed by dedicated instructions. Each operation leaves the block as a one-cycle strobe toward the storage, and it is timed by the second rising TCK edge that the TAP spends in Run-Test-Idle. The store is an internal register file. It holds the signature and a security bit that hides the signature from scan readback. A read after any write or erase returns zeros until a discharge has run. The store and the security bit are cleared only by the power-on reset `por_n` or by a bulk erase. The TAP's own Test-Logic-Reset state leaves them untouched.

The TAP states are Test-Logic-Reset (S_RESET), Run-Test-Idle (S_IDLE), and for each of the DR and IR columns: Select, Capture, Shift, Exit1, Pause, Exit2 and Update. With TMS=1 the transitions are: S_RESET to itself; S_IDLE to Select-DR; Select-DR to Select-IR; Select-IR to S_RESET; Capture, Shift and Exit2 to the Exit1 or Update of their column; Exit1 to Update; Pause to Exit2; Update to Select-DR. With TMS=0 the transitions are: S_RESET and Update to S_IDLE; S_IDLE to itself; each Select to its Capture; Capture and Exit2 to Shift; Shift to itself; Exit1 to Pause; Pause to itself.

Top module: `nvprog_tap`

## Requirements
- R1: The TAP follows the 16-state graph above. Five rising TCK edges with TMS=1 reach Test-Logic-Reset from any state. `por_n` low forces Test-Logic-Reset asynchronously.
- R2: The instruction register is 8 bits, shifted LSB first. It loads 8'h01 in Capture-IR and takes the shifted value in Update-IR. Test-Logic-Reset loads the identity opcode. Opcodes: identity 8'h16, signature read 8'h15, signature write 8'h1A, arm 8'h28, disarm 8'h1E, erase 8'h03, lock 8'h09, discharge 8'h14.
- R3: The identity register captures {version[3:0]=4'h2, part[15:0]=16'h5A3C, maker[10:0]=11'h0B5, 1'b1} (MSB to LSB) and shifts out LSB first.
- R4: Every opcode other than identity, signature read and signature write selects a 1-bit bypass stage. The bypass stage captures 0 and delays TDI by one shift.
- R5: An Update-IR with the arm opcode sets programming mode. An Update-IR with the disarm opcode clears it, and so does any edge spent in Test-Logic-Reset.
- R6: With erase, lock, signature write or discharge loaded and programming mode set, exactly one one-cycle strobe (the one for that operation) rises on the second rising edge spent in Run-Test-Idle. The strobe fires once per stay, and nothing fires if the TAP leaves after one edge.
- R7: Without programming mode, the four gated opcodes raise no strobe and leave the stored signature unchanged.
- R8: Signature read loads the stored signature in Capture-DR and shifts it out LSB first. A signature-write strobe stores the signature shift register's contents.
- R9: A lock strobe sets the security bit. While it is set, signature read shifts out zeros. The bit survives disarm and Test-Logic-Reset, and an erase strobe clears it together with the signature (to zero).
- R10: After an erase, lock or signature-write strobe, signature read shifts out zeros until a discharge strobe has fired.
- R11: TDO and its enable change only on falling TCK edges. The enable is high only in Shift-DR and Shift-IR, and TDO is 0 while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; also erases the store |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_oe | output | 1 | TDO drive enable |
| nv_erase | output | 1 | Bulk erase strobe |
| nv_secure | output | 1 | Security lock strobe |
| nv_sigwr | output | 1 | Signature write strobe |
| nv_discharge | output | 1 | Discharge strobe |

## Verification
The bench builds the block with its default parameters: a 32-bit signature, a firing edge of 2 and the identity fields listed in R3. An 8-bit instruction register allows a sweep over all 256 opcodes, so every opcode outside the defined set is checked for bypass behaviour, with no strobe fired. The short 2-edge firing window makes it possible to check the exact strobe edge, a one-edge stay, and a stay that is too long to fire twice. Six computed signature patterns are then taken through write, discharge and read, and the lock, Test-Logic-Reset and erase sequence is run on top of them.

// File: rtl/nvprog_pkg.sv
package nvprog_pkg;

    localparam int IR_W = 8;

    localparam logic [IR_W-1:0] IR_CAPTURE = 8'h01;
    localparam logic [IR_W-1:0] OP_IDENT   = 8'h16;
    localparam logic [IR_W-1:0] OP_SIG_RD  = 8'h15;
    localparam logic [IR_W-1:0] OP_SIG_WR  = 8'h1A;
    localparam logic [IR_W-1:0] OP_ARM     = 8'h28;
    localparam logic [IR_W-1:0] OP_DISARM  = 8'h1E;
    localparam logic [IR_W-1:0] OP_ERASE   = 8'h03;
    localparam logic [IR_W-1:0] OP_LOCK    = 8'h09;
    localparam logic [IR_W-1:0] OP_DISCH   = 8'h14;

    typedef enum logic [3:0] {
        S_RESET, S_IDLE,
        S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
        S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {
        DR_BYPASS, DR_IDENT, DR_SIG
    } dr_sel_e;

    typedef struct packed {
        logic erase;
        logic secure;
        logic sigwr;
        logic discharge;
    } nv_cmd_t;

endpackage

// File: rtl/nvprog_fsm.sv
module nvprog_fsm
    import nvprog_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e state_nx;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) state <= S_RESET;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_RESET:  state_nx = tms ? S_RESET  : S_IDLE;
            S_IDLE:   state_nx = tms ? S_SEL_DR : S_IDLE;
            S_SEL_DR: state_nx = tms ? S_SEL_IR : S_CAP_DR;
            S_CAP_DR: state_nx = tms ? S_EX1_DR : S_SH_DR;
            S_SH_DR:  state_nx = tms ? S_EX1_DR : S_SH_DR;
            S_EX1_DR: state_nx = tms ? S_UPD_DR : S_PAU_DR;
            S_PAU_DR: state_nx = tms ? S_EX2_DR : S_PAU_DR;
            S_EX2_DR: state_nx = tms ? S_UPD_DR : S_SH_DR;
            S_UPD_DR: state_nx = tms ? S_SEL_DR : S_IDLE;
            S_SEL_IR: state_nx = tms ? S_RESET  : S_CAP_IR;
            S_CAP_IR: state_nx = tms ? S_EX1_IR : S_SH_IR;
            S_SH_IR:  state_nx = tms ? S_EX1_IR : S_SH_IR;
            S_EX1_IR: state_nx = tms ? S_UPD_IR : S_PAU_IR;
            S_PAU_IR: state_nx = tms ? S_EX2_IR : S_PAU_IR;
            S_EX2_IR: state_nx = tms ? S_UPD_IR : S_SH_IR;
            S_UPD_IR: state_nx = tms ? S_SEL_DR : S_IDLE;
        endcase
    end

endmodule

// File: rtl/nvprog_seq.sv
module nvprog_seq
    import nvprog_pkg::*;
#(
    parameter int FIRE_EDGE = 2
) (
    input  logic            tck,
    input  logic            por_n,
    input  tap_state_e      state,
    input  logic [IR_W-1:0] ir_q,
    input  logic [IR_W-1:0] ir_load,
    output nv_cmd_t         cmd,
    output logic            prog_mode,
    output logic            need_dis
);

    localparam int CW = $clog2(FIRE_EDGE + 1);

    logic [CW-1:0] rti_cnt;
    logic          fire;
    nv_cmd_t       cmd_d;

    always_comb begin
        fire  = (state == S_IDLE) && prog_mode && (rti_cnt == CW'(FIRE_EDGE - 1));
        cmd_d = '0;
        if (fire) begin
            cmd_d.erase     = (ir_q == OP_ERASE);
            cmd_d.secure    = (ir_q == OP_LOCK);
            cmd_d.sigwr     = (ir_q == OP_SIG_WR);
            cmd_d.discharge = (ir_q == OP_DISCH);
        end
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            rti_cnt   <= '0;
            prog_mode <= 1'b0;
            need_dis  <= 1'b0;
            cmd       <= '0;
        end else begin
            cmd <= cmd_d;
            if (state == S_IDLE) begin
                if (rti_cnt != CW'(FIRE_EDGE)) rti_cnt <= rti_cnt + CW'(1);
            end else begin
                rti_cnt <= '0;
            end
            if (state == S_RESET) begin
                prog_mode <= 1'b0;
            end else if (state == S_UPD_IR) begin
                if (ir_load == OP_ARM)         prog_mode <= 1'b1;
                else if (ir_load == OP_DISARM) prog_mode <= 1'b0;
            end
            if (cmd_d.erase || cmd_d.secure || cmd_d.sigwr) need_dis <= 1'b1;
            else if (cmd_d.discharge)                       need_dis <= 1'b0;
        end
    end

endmodule

// File: rtl/nvprog_store.sv
module nvprog_store
    import nvprog_pkg::*;
#(
    parameter int SIG_W = 32
) (
    input  logic             tck,
    input  logic             por_n,
    input  nv_cmd_t          cmd,
    input  logic [SIG_W-1:0] sig_in,
    output logic [SIG_W-1:0] sig_q,
    output logic             secured
);

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            sig_q   <= '0;
            secured <= 1'b0;
        end else if (cmd.erase) begin
            sig_q   <= '0;
            secured <= 1'b0;
        end else begin
            if (cmd.secure) secured <= 1'b1;
            if (cmd.sigwr)  sig_q   <= sig_in;
        end
    end

endmodule

// File: rtl/nvprog_tap.sv
module nvprog_tap
    import nvprog_pkg::*;
#(
    parameter int          SIG_W      = 32,
    parameter int          FIRE_EDGE  = 2,
    parameter logic [3:0]  ID_VERSION = 4'h2,
    parameter logic [15:0] ID_PART    = 16'h5A3C,
    parameter logic [10:0] ID_MAKER   = 11'h0B5
) (
    input  logic tck,
    input  logic por_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_oe,
    output logic nv_erase,
    output logic nv_secure,
    output logic nv_sigwr,
    output logic nv_discharge
);

    localparam int ID_W = 4 + 16 + 11 + 1;
    localparam logic [ID_W-1:0] ID_WORD = {ID_VERSION, ID_PART, ID_MAKER, 1'b1};

    tap_state_e       state;
    nv_cmd_t          cmd;
    logic             prog_mode;
    logic             need_dis;
    logic             secured;
    logic [IR_W-1:0]  ir_q;
    logic [IR_W-1:0]  ir_sh;
    logic [ID_W-1:0]  id_sh;
    logic [SIG_W-1:0] sig_sh;
    logic [SIG_W-1:0] sig_q;
    logic [SIG_W-1:0] rd_data;
    logic             byp_q;
    dr_sel_e          dr_sel;
    logic             dr_lsb;

    nvprog_fsm u_fsm (
        .tck   (tck),
        .por_n (por_n),
        .tms   (tms),
        .state (state)
    );

    nvprog_seq #(.FIRE_EDGE(FIRE_EDGE)) u_seq (
        .tck       (tck),
        .por_n     (por_n),
        .state     (state),
        .ir_q      (ir_q),
        .ir_load   (ir_sh),
        .cmd       (cmd),
        .prog_mode (prog_mode),
        .need_dis  (need_dis)
    );

    nvprog_store #(.SIG_W(SIG_W)) u_store (
        .tck     (tck),
        .por_n   (por_n),
        .cmd     (cmd),
        .sig_in  (sig_sh),
        .sig_q   (sig_q),
        .secured (secured)
    );

    assign nv_erase     = cmd.erase;
    assign nv_secure    = cmd.secure;
    assign nv_sigwr     = cmd.sigwr;
    assign nv_discharge = cmd.discharge;

    assign rd_data = (secured || need_dis) ? '0 : sig_q;

    always_comb begin
        unique case (ir_q)
            OP_IDENT:            dr_sel = DR_IDENT;
            OP_SIG_RD, OP_SIG_WR: dr_sel = DR_SIG;
            default:             dr_sel = DR_BYPASS;
        endcase
    end

    always_comb begin
        unique case (dr_sel)
            DR_IDENT: dr_lsb = id_sh[0];
            DR_SIG:   dr_lsb = sig_sh[0];
            default:  dr_lsb = byp_q;
        endcase
    end

    // instruction path
    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            ir_q  <= OP_IDENT;
            ir_sh <= IR_CAPTURE;
        end else begin
            unique case (state)
                S_RESET:  ir_q  <= OP_IDENT;
                S_CAP_IR: ir_sh <= IR_CAPTURE;
                S_SH_IR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
                S_UPD_IR: ir_q  <= ir_sh;
                default:  ;
            endcase
        end
    end

    // data registers
    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            id_sh  <= ID_WORD;
            sig_sh <= '0;
            byp_q  <= 1'b0;
        end else if (state == S_CAP_DR) begin
            unique case (dr_sel)
                DR_IDENT: id_sh <= ID_WORD;
                DR_SIG:   if (ir_q == OP_SIG_RD) sig_sh <= rd_data;
                default:  byp_q <= 1'b0;
            endcase
        end else if (state == S_SH_DR) begin
            unique case (dr_sel)
                DR_IDENT: id_sh  <= {tdi, id_sh[ID_W-1:1]};
                DR_SIG:   sig_sh <= {tdi, sig_sh[SIG_W-1:1]};
                default:  byp_q  <= tdi;
            endcase
        end
    end

    // serial output on the falling edge
    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else if (state == S_SH_IR) begin
            tdo    <= ir_sh[0];
            tdo_oe <= 1'b1;
        end else if (state == S_SH_DR) begin
            tdo    <= dr_lsb;
            tdo_oe <= 1'b1;
        end else begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end
    end

endmodule

// File: rtl/nvprog_chk.sv
module nvprog_chk
    import nvprog_pkg::*;
(
    input logic       tck,
    input logic       por_n,
    input tap_state_e state,
    input nv_cmd_t    cmd,
    input logic       prog_mode,
    input logic       secured,
    input logic       tdo_oe
);

    p_single_cmd_r6: assert property (@(posedge tck) disable iff (!por_n)
        $onehot0(cmd));

    p_cmd_edge_r6: assert property (@(posedge tck) disable iff (!por_n)
        (|cmd) |-> ($past(state) == S_IDLE && $past(state, 2) == S_IDLE
                    && $past(state, 3) != S_IDLE));

    p_cmd_pulse_r6: assert property (@(posedge tck) disable iff (!por_n)
        (|cmd) |=> !(|cmd));

    p_cmd_gated_r7: assert property (@(posedge tck) disable iff (!por_n)
        (|cmd) |-> $past(prog_mode));

    p_reset_disarms_r5: assert property (@(posedge tck) disable iff (!por_n)
        (state == S_RESET) |=> !prog_mode);

    p_lock_sticky_r9: assert property (@(posedge tck) disable iff (!por_n)
        (secured && !cmd.erase) |=> secured);

    p_oe_shift_r11: assert property (@(posedge tck) disable iff (!por_n)
        tdo_oe |-> (state == S_SH_DR || state == S_SH_IR));

endmodule

bind nvprog_tap nvprog_chk u_chk (
    .tck       (tck),
    .por_n     (por_n),
    .state     (state),
    .cmd       (cmd),
    .prog_mode (prog_mode),
    .secured   (secured),
    .tdo_oe    (tdo_oe)
);

// File: tb/sim_nvprog_tap.sv
`timescale 1ns/100ps
module sim_nvprog_tap;

    localparam logic [7:0] OP_IDENT  = 8'h16;
    localparam logic [7:0] OP_SIG_RD = 8'h15;
    localparam logic [7:0] OP_SIG_WR = 8'h1A;
    localparam logic [7:0] OP_ARM    = 8'h28;
    localparam logic [7:0] OP_DISARM = 8'h1E;
    localparam logic [7:0] OP_ERASE  = 8'h03;
    localparam logic [7:0] OP_LOCK   = 8'h09;
    localparam logic [7:0] OP_DISCH  = 8'h14;

    logic tck = 1'b0;
    logic por_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic tdo, tdo_oe, nv_erase, nv_secure, nv_sigwr, nv_discharge;

    int total = 0;
    int bad = 0;
    int edge_bad = 0;
    int n_stb = 0;

    nvprog_tap u0 (
        .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
        .nv_erase(nv_erase), .nv_secure(nv_secure), .nv_sigwr(nv_sigwr),
        .nv_discharge(nv_discharge)
    );

    always #2.5 tck = ~tck;

    always @(negedge tck)
        if (nv_erase || nv_secure || nv_sigwr || nv_discharge) n_stb++;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one rising edge; returns TDO as seen just before it
    task automatic step(input logic m, input logic d, output logic o);
        tms = m;
        tdi = d;
        o = tdo;
        @(posedge tck);
        #0.5;
        if (tdo !== o) edge_bad++;
        @(negedge tck);
        #0.5;
    endtask

    task automatic reset_tap();
        logic o;
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
    endtask

    task automatic shift_ir(input logic [7:0] op, output logic [7:0] cap);
        logic o;
        step(1'b1, 1'b0, o);
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        for (int i = 0; i < 8; i++) begin
            step(i == 7, op[i], o);
            cap[i] = o;
        end
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
    endtask

    task automatic shift_dr(input int n, input logic [31:0] din, output logic [31:0] dout);
        logic o;
        dout = '0;
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
        step(1'b0, 1'b0, o);
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i], o);
            dout[i] = o;
        end
        step(1'b1, 1'b0, o);
        step(1'b0, 1'b0, o);
    endtask

    task automatic idle(input int k, output logic [3:0] seen, output int first);
        logic o;
        logic [3:0] s;
        seen = '0;
        first = 0;
        for (int i = 1; i <= k; i++) begin
            step(1'b0, 1'b0, o);
            s = {nv_erase, nv_secure, nv_sigwr, nv_discharge};
            if (s != 0 && first == 0) first = i;
            seen |= s;
        end
    endtask

    task automatic ir(input logic [7:0] op);
        logic [7:0] c;
        shift_ir(op, c);
    endtask

    task automatic run_op(input logic [7:0] op, output logic [3:0] seen, output int first);
        ir(op);
        idle(3, seen, first);
    endtask

    task automatic read_sig(output logic [31:0] v);
        ir(OP_SIG_RD);
        shift_dr(32, 32'h0, v);
    endtask

    task automatic write_sig(input logic [31:0] v, output logic [3:0] seen, output int first);
        logic [31:0] junk;
        ir(OP_SIG_WR);
        shift_dr(32, v, junk);
        idle(3, seen, first);
    endtask

    function automatic bit defined_op(input logic [7:0] op);
        return op == OP_IDENT || op == OP_SIG_RD || op == OP_SIG_WR || op == OP_ARM ||
               op == OP_DISARM || op == OP_ERASE || op == OP_LOCK || op == OP_DISCH;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge tck);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [7:0]  cap;
        logic [31:0] v, idw, pat, d1, d2;
        logic [3:0]  seen;
        logic        o;
        int          first, base;

        idw = (32'h2 << 28) | (32'h5A3C << 12) | (32'h0B5 << 1) | 32'h1;
        d1  = 32'hC3A5_0F96;
        d2  = 32'h1357_9BDF;

        repeat (3) @(negedge tck);
        #0.5;
        chk(tdo_oe == 1'b0 && tdo == 1'b0, "R11 reset tdo idle", {30'h0, tdo_oe, tdo}, 32'h0);
        chk({nv_erase, nv_secure, nv_sigwr, nv_discharge} == 4'b0, "R6 reset strobes",
            {28'h0, nv_erase, nv_secure, nv_sigwr, nv_discharge}, 32'h0);
        por_n = 1'b1;
        step(1'b0, 1'b0, o);

        // R2 reset opcode and R3 identity word, no IR scan
        shift_dr(32, 32'h0, v);
        chk(v == idw, "R3 identity after reset", v, idw);

        // R1: abandon an IR scan midway, five TMS ones reach reset
        step(1'b1, 1'b0, o); step(1'b1, 1'b0, o); step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, o);
        reset_tap();
        shift_dr(32, 32'h0, v);
        chk(v == idw, "R1 five TMS ones restore reset opcode", v, idw);

        // R2 capture pattern
        shift_ir(8'hFF, cap);
        chk(cap == 8'h01, "R2 IR capture pattern", {24'h0, cap}, 32'h01);
        chk(tdo_oe == 1'b0, "R11 enable low in idle", {31'h0, tdo_oe}, 32'h0);

        // R4 sweep of every undefined opcode
        base = n_stb;
        for (int op = 0; op < 256; op++) begin
            if (!defined_op(8'(op))) begin
                pat = {24'h0, 8'(op) ^ 8'hA5};
                ir(8'(op));
                shift_dr(8, pat, v);
                chk(v[7:0] == {pat[6:0], 1'b0}, "R4 bypass delay", v, {24'h0, pat[6:0], 1'b0});
            end
        end
        chk(n_stb == base, "R7 no strobes during sweep", n_stb, base);

        // R7 gated op without programming mode
        run_op(OP_ERASE, seen, first);
        chk(seen == 4'b0, "R7 erase unarmed", {28'h0, seen}, 32'h0);

        // R6 / R8 signature write under programming mode
        ir(OP_ARM);
        write_sig(d1, seen, first);
        chk(seen == 4'b0010, "R6 write strobe only", {28'h0, seen}, 32'h2);
        chk(first == 2, "R6 fires on second idle edge", first, 2);
        read_sig(v);
        chk(v == 32'h0, "R10 read blocked before discharge", v, 32'h0);
        run_op(OP_DISCH, seen, first);
        chk(seen == 4'b0001 && first == 2, "R6 discharge strobe", {seen, 28'(first)}, {4'b0001, 28'd2});
        read_sig(v);
        chk(v == d1, "R8 signature readback", v, d1);

        // R6 leaving after one idle edge fires nothing
        base = n_stb;
        ir(OP_ERASE);
        read_sig(v);
        chk(n_stb == base, "R6 single idle edge no strobe", n_stb, base);
        chk(v == d1, "R6 signature intact after aborted erase", v, d1);

        // R5 disarm, then erase is ignored
        ir(OP_DISARM);
        run_op(OP_ERASE, seen, first);
        chk(seen == 4'b0, "R5 disarm blocks erase", {28'h0, seen}, 32'h0);
        read_sig(v);
        chk(v == d1, "R7 storage unchanged unarmed", v, d1);

        // R8 pattern sweep
        ir(OP_ARM);
        for (int k = 0; k < 6; k++) begin
            pat = (32'h1 << (k * 5)) ^ (32'h9E37_79B9 * (k + 1));
            write_sig(pat, seen, first);
            run_op(OP_DISCH, seen, first);
            read_sig(v);
            chk(v == pat, "R8 pattern write/read", v, pat);
        end

        // R9 lock
        run_op(OP_LOCK, seen, first);
        chk(seen == 4'b0100 && first == 2, "R9 lock strobe", {seen, 28'(first)}, {4'b0100, 28'd2});
        run_op(OP_DISCH, seen, first);
        read_sig(v);
        chk(v == 32'h0, "R9 locked read zero", v, 32'h0);
        ir(OP_IDENT);
        shift_dr(32, 32'h0, v);
        chk(v == idw, "R3 identity readable while locked", v, idw);

        // R5 reset state disarms; R9 lock survives disarm and reset
        ir(OP_DISARM);
        ir(OP_ARM);
        reset_tap();
        run_op(OP_ERASE, seen, first);
        chk(seen == 4'b0, "R5 reset clears programming mode", {28'h0, seen}, 32'h0);
        ir(OP_ARM);
        run_op(OP_DISCH, seen, first);
        read_sig(v);
        chk(v == 32'h0, "R9 lock survives reset and disarm", v, 32'h0);

        // R9 erase clears lock and signature
        run_op(OP_ERASE, seen, first);
        chk(seen == 4'b1000 && first == 2, "R9 erase strobe", {seen, 28'(first)}, {4'b1000, 28'd2});
        run_op(OP_DISCH, seen, first);
        read_sig(v);
        chk(v == 32'h0, "R9 erase clears signature", v, 32'h0);
        write_sig(d2, seen, first);
        run_op(OP_DISCH, seen, first);
        read_sig(v);
        chk(v == d2, "R9 erase clears lock", v, d2);

        // R11 TDO never moved on a rising edge
        chk(edge_bad == 0, "R11 tdo stable across rising edges", edge_bad, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule